// File: doc/BRIEF.md
# Two-wire serial port byte buffer and status flags

This block is the register-facing half of a two-wire serial bus controller. It holds a single data byte that is shared by transmit and receive, and it runs the transmit-empty and receive-full handshakes between software and the byte shifter of the bus engine. It also keeps a status word of event and error flags. The engine reports what happened on the bus through one-cycle pulses on its inputs. Software reads the status word and the data byte through a simple register port. It clears error flags by writing zeros.

When transmitting, a register write places a byte in the buffer. The engine then sees it on `tx_byte`, and it pulses `tx_load` when it moves the byte into its shift register. When receiving, the engine pulses `rx_valid` with a completed byte, and software reads it from the data register. The buffer does not detect write collisions.

If arbitration is lost during the acknowledge bit, the received byte is discarded. A matched slave address only ever raises a status flag and never reaches the data byte. When the peripheral enable input is low, every error flag is held cleared.

Top module: `twi_data_status`

## Requirements
- R1: After reset, the data word at byte offset 0x10 and the status word at offset 0x14 both read 0x0000.
- R2: Bits 7:0 of the data word hold the buffered byte. Bits 15:8 always read 0, whatever value was written to them.
- R3: A write to offset 0x10 stores bits 7:0 of the write data, drives them on `tx_byte` and clears TxE (status bit 7). A `tx_load` pulse sets TxE at the next clock edge. When both land in the same cycle, TxE ends at 1.
- R4: A write to the data word is accepted while TxE is 0 and raises no status bit.
- R5: A `rx_valid` pulse with `rx_arlo` low copies `rx_byte` into the buffer and sets RxNE (status bit 6). A read of offset 0x10 with `reg_rd` high returns the byte and clears RxNE.
- R6: A `rx_valid` pulse with `rx_arlo` high leaves both the buffered byte and RxNE unchanged.
- R7: A byte that completes while RxNE is 1, and that is not being read in that cycle, sets OVR (status bit 11). The earlier byte stays in the buffer.
- R8: Bit i of `evt_set` sets status bit i, and bit i of `evt_clr` clears it. The mapping is 0 start sent, 1 address matched, 2 byte transfer done, 3 ten-bit header sent, 4 stop seen. These events never alter the data byte.
- R9: The error flags sit at status bits 8 bus error, 9 arbitration lost, 10 no acknowledge, 11 overrun, 12 checksum error, 14 timeout and 15 alert. `err_evt` bits 0 to 6 raise them in that order. Writing 0 to a flag's bit at offset 0x14 clears it, and writing 1 leaves it unchanged.
- R10: Writes to offset 0x14 never change status bits 7:0. Status bits 13 and 5 always read 0.
- R11: A hardware raise of an error flag wins over a software clear of that flag in the same cycle.
- R12: While `enable` is low, all error flags are cleared at each clock edge and cannot be raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Peripheral enable; low clears error flags |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on the data word) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the current address |
| tx_byte | output | 8 | Buffered byte offered to the shifter |
| tx_load | input | 1 | Shifter took the byte |
| rx_valid | input | 1 | Shifter completed a received byte |
| rx_arlo | input | 1 | Arbitration was lost during the acknowledge of that byte |
| rx_byte | input | 8 | Received byte |
| err_evt | input | 7 | Error raise pulses, in the order of R9 |
| evt_set | input | 5 | Event flag raise pulses, in the order of R8 |
| evt_clr | input | 5 | Event flag clear pulses, in the order of R8 |

## Verification
The hardest situations to reach are the same-cycle races. One is a hardware error raise in the same cycle as a software zero-write. Another is a shifter load in the same cycle as a data write. A third is a second byte that completes while the first is still unread. The directed tasks drive both sides within a single clock period, with the engine pulse and the register strobe set up at the same falling edge, so that they meet at one rising edge. After each race, the status word is read back through the register port to show which side won.

// File: rtl/twi_ds_pkg.sv
package twi_ds_pkg;

    localparam int NUM_ERR = 7;
    localparam int NUM_EVT = 5;
    localparam int TXE_POS  = 7;
    localparam int RXNE_POS = 6;

    typedef struct packed {
        logic [NUM_ERR-1:0] err;
        logic               txe;
        logic               rxne;
        logic [NUM_EVT-1:0] evt;
    } flags_t;

    // status bit that carries error flag i (bit 13 is skipped)
    function automatic int err_pos(input int i);
        return (i < 5) ? (8 + i) : (9 + i);
    endfunction

    function automatic logic [15:0] pack_status(input flags_t f);
        logic [15:0] w;
        w = '0;
        for (int i = 0; i < NUM_EVT; i++) w[i] = f.evt[i];
        w[RXNE_POS] = f.rxne;
        w[TXE_POS]  = f.txe;
        for (int i = 0; i < NUM_ERR; i++) w[err_pos(i)] = f.err[i];
        return w;
    endfunction

    // bits written as 1 keep their error flag
    function automatic logic [NUM_ERR-1:0] keep_mask(input logic [15:0] w);
        logic [NUM_ERR-1:0] k;
        for (int i = 0; i < NUM_ERR; i++) k[i] = w[err_pos(i)];
        return k;
    endfunction

endpackage

// File: rtl/twi_ds_databuf.sv
module twi_ds_databuf #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_dr,
    input  logic              rd_dr,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              tx_load,
    input  logic              rx_valid,
    input  logic              rx_arlo,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] data_q,
    output logic              txe,
    output logic              rxne,
    output logic              overrun
);
    logic accept;

    assign accept  = rx_valid && !rx_arlo;
    assign overrun = accept && rxne && !rd_dr;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (accept && !overrun) begin
            data_q <= rx_byte;
        end else if (wr_dr) begin
            data_q <= wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxne <= 1'b0;
        end else if (accept) begin
            rxne <= 1'b1;
        end else if (rd_dr) begin
            rxne <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txe <= 1'b0;
        end else if (tx_load) begin
            txe <= 1'b1;
        end else if (wr_dr) begin
            txe <= 1'b0;
        end
    end
endmodule

// File: rtl/twi_ds_errflags.sv
module twi_ds_errflags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         sw_wr,
    input  logic [N-1:0] sw_keep,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || !enable) begin
                q[i] <= 1'b0;
            end else if (hw_set[i]) begin
                q[i] <= 1'b1;
            end else if (sw_wr && !sw_keep[i]) begin
                q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/twi_ds_evtflags.sv
module twi_ds_evtflags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr[i]) begin
                q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/twi_data_status.sv
module twi_data_status
    import twi_ds_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          REG_W    = 16,
    parameter int          BYTE_W   = 8,
    parameter logic [7:0]  DATA_OFS = 8'h10,
    parameter logic [7:0]  STAT_OFS = 8'h14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_load,
    input  logic              rx_valid,
    input  logic              rx_arlo,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [NUM_ERR-1:0] err_evt,
    input  logic [NUM_EVT-1:0] evt_set,
    input  logic [NUM_EVT-1:0] evt_clr
);
    localparam int OVR_IDX = 3;

    logic               hit_dr, hit_sr;
    logic               wr_dr, rd_dr, wr_sr;
    logic               overrun;
    logic [NUM_ERR-1:0] err_raise;
    flags_t             flags;
    logic [15:0]        status_w;
    logic [BYTE_W-1:0]  data_q;

    assign hit_dr = (reg_addr == ADDR_W'(DATA_OFS));
    assign hit_sr = (reg_addr == ADDR_W'(STAT_OFS));
    assign wr_dr  = reg_wr && hit_dr;
    assign rd_dr  = reg_rd && hit_dr;
    assign wr_sr  = reg_wr && hit_sr;

    twi_ds_databuf #(.BYTE_W(BYTE_W)) i_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_dr    (wr_dr),
        .rd_dr    (rd_dr),
        .wbyte    (reg_wdata[BYTE_W-1:0]),
        .tx_load  (tx_load),
        .rx_valid (rx_valid),
        .rx_arlo  (rx_arlo),
        .rx_byte  (rx_byte),
        .data_q   (data_q),
        .txe      (flags.txe),
        .rxne     (flags.rxne),
        .overrun  (overrun)
    );

    always_comb begin
        err_raise = err_evt;
        err_raise[OVR_IDX] = err_evt[OVR_IDX] | overrun;
    end

    twi_ds_errflags #(.N(NUM_ERR)) i_err (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .sw_wr   (wr_sr),
        .sw_keep (keep_mask(16'(reg_wdata))),
        .hw_set  (err_raise),
        .q       (flags.err)
    );

    twi_ds_evtflags #(.N(NUM_EVT)) i_evt (
        .clk (clk),
        .rst (rst),
        .set (evt_set),
        .clr (evt_clr),
        .q   (flags.evt)
    );

    assign status_w = pack_status(flags);
    assign tx_byte  = data_q;

    always_comb begin
        reg_rdata = '0;
        if (hit_dr) begin
            reg_rdata[BYTE_W-1:0] = data_q;
        end else if (hit_sr) begin
            reg_rdata = REG_W'(status_w);
        end
    end
endmodule

// File: rtl/twi_data_status_chk.sv
module twi_data_status_chk (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        rx_valid,
    input logic        rx_arlo,
    input logic        tx_load,
    input logic        wr_dr,
    input logic        rd_dr,
    input logic        wr_sr,
    input logic [6:0]  err_evt,
    input logic [4:0]  evt_set,
    input logic [15:0] status,
    input logic [7:0]  tx_byte
);
    assert_txe_set_R3: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> status[7]);

    assert_rx_lands_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_arlo) |=> status[6]);

    assert_arlo_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_arlo && !wr_dr) |=> (tx_byte == $past(tx_byte)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (enable && rx_valid && !rx_arlo && status[6] && !rd_dr) |=> status[11]);

    assert_ro_low_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_sr && evt_set == '0) |=> ((status[4:0] & ~$past(status[4:0])) == '0));

    assert_hw_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (enable && err_evt[2] && wr_sr) |=> status[10]);

    assert_off_clears_R12: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ({status[15:14], status[12:8]} == '0));
endmodule

bind twi_data_status twi_data_status_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .rx_valid (rx_valid),
    .rx_arlo  (rx_arlo),
    .tx_load  (tx_load),
    .wr_dr    (wr_dr),
    .rd_dr    (rd_dr),
    .wr_sr    (wr_sr),
    .err_evt  (err_evt),
    .evt_set  (evt_set),
    .status   (status_w),
    .tx_byte  (tx_byte)
);

// File: tb/test_twi_data_status.sv
`timescale 1ns/1ps
module test_twi_data_status;
    logic        clk = 0;
    logic        rst = 1;
    logic        enable = 1;
    logic [7:0]  reg_addr = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic [7:0]  tx_byte;
    logic        tx_load = 0, rx_valid = 0, rx_arlo = 0;
    logic [7:0]  rx_byte = 0;
    logic [6:0]  err_evt = 0;
    logic [4:0]  evt_set = 0, evt_clr = 0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    localparam logic [7:0] DR = 8'h10, SR = 8'h14;

    always #4 clk = ~clk;

    twi_data_status i_twi_data_status (
        .clk(clk), .rst(rst), .enable(enable), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_byte(tx_byte), .tx_load(tx_load),
        .rx_valid(rx_valid), .rx_arlo(rx_arlo), .rx_byte(rx_byte),
        .err_evt(err_evt), .evt_set(evt_set), .evt_clr(evt_clr)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_wr = 0; reg_rd = 0;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic pulse_rx(input logic [7:0] b, input logic arlo);
        @(negedge clk);
        rx_valid = 1; rx_byte = b; rx_arlo = arlo;
        @(negedge clk);
        rx_valid = 0; rx_arlo = 0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        peek(DR, v); check("R1 data", v, 16'h0000);
        peek(SR, v); check("R1 status", v, 16'h0000);
    endtask

    task automatic t_tx;
        logic [15:0] v;
        wr(DR, 16'hFFA5);
        peek(DR, v); check("R2 upper zero", v, 16'h00A5);
        check("R3 tx_byte", {8'h00, tx_byte}, 16'h00A5);
        peek(SR, v); check("R3 txe cleared", v & 16'h0080, 16'h0000);
        @(negedge clk); tx_load = 1; @(negedge clk); tx_load = 0;
        peek(SR, v); check("R3 txe set", v & 16'h0080, 16'h0080);
    endtask

    task automatic t_nocollide;
        logic [15:0] v;
        wr(DR, 16'h003C);
        wr(DR, 16'h005D);
        peek(DR, v); check("R4 write while busy", v, 16'h005D);
        peek(SR, v); check("R4 no flag", v, 16'h0000);
        @(negedge clk);
        reg_addr = DR; reg_wdata = 16'h0011; reg_wr = 1; tx_load = 1;
        @(negedge clk);
        reg_wr = 0; tx_load = 0;
        peek(SR, v); check("R3 load beats write", v, 16'h0080);
        peek(DR, v); check("R3 byte stored", v, 16'h0011);
    endtask

    task automatic t_rx;
        logic [15:0] v;
        pulse_rx(8'h5A, 0);
        peek(DR, v); check("R5 byte copied", v, 16'h005A);
        peek(SR, v); check("R5 rxne set", v, 16'h00C0);
        @(negedge clk); reg_addr = DR; reg_rd = 1; #1 v = reg_rdata;
        check("R5 read value", v, 16'h005A);
        @(negedge clk); reg_rd = 0;
        peek(SR, v); check("R5 rxne cleared", v, 16'h0080);
    endtask

    task automatic t_arlo;
        logic [15:0] v;
        pulse_rx(8'h77, 1);
        peek(DR, v); check("R6 byte dropped", v, 16'h005A);
        peek(SR, v); check("R6 rxne stays", v, 16'h0080);
    endtask

    task automatic t_overrun;
        logic [15:0] v;
        pulse_rx(8'h11, 0);
        pulse_rx(8'h22, 0);
        peek(DR, v); check("R7 first kept", v, 16'h0011);
        peek(SR, v); check("R7 ovr set", v, 16'h08C0);
        @(negedge clk); reg_addr = DR; reg_rd = 1;
        @(negedge clk); reg_rd = 0;
        wr(SR, 16'hF7FF);
        peek(SR, v); check("R9 ovr cleared", v, 16'h0080);
    endtask

    task automatic t_events;
        logic [15:0] v;
        @(negedge clk); evt_set = 5'b00010; @(negedge clk); evt_set = 0;
        peek(SR, v); check("R8 addr flag", v, 16'h0082);
        peek(DR, v); check("R8 data untouched", v, 16'h0011);
        @(negedge clk); evt_clr = 5'b00010; @(negedge clk); evt_clr = 0;
        peek(SR, v); check("R8 cleared", v, 16'h0080);
    endtask

    task automatic t_errors;
        logic [15:0] v;
        @(negedge clk); err_evt = 7'h7F; @(negedge clk); err_evt = 0;
        peek(SR, v); check("R9 all raised", v, 16'hDF80);
        wr(SR, 16'hFFFF);
        peek(SR, v); check("R9 ones keep", v, 16'hDF80);
        wr(SR, 16'hFBFF);
        peek(SR, v); check("R9 af cleared", v, 16'hDB80);
    endtask

    task automatic t_readonly;
        logic [15:0] v;
        @(negedge clk); evt_set = 5'b10001; @(negedge clk); evt_set = 0;
        wr(SR, 16'h0000);
        peek(SR, v); check("R10 low byte kept", v, 16'h0091);
        wr(SR, 16'hFFFF);
        peek(SR, v); check("R10 reserved zero", v & 16'h2020, 16'h0000);
        check("R10 ones no effect", v, 16'h0091);
        @(negedge clk); evt_clr = 5'b11111; @(negedge clk); evt_clr = 0;
    endtask

    task automatic t_race;
        logic [15:0] v;
        @(negedge clk);
        reg_addr = SR; reg_wdata = 16'h0000; reg_wr = 1; err_evt = 7'b0000100;
        @(negedge clk);
        reg_wr = 0; err_evt = 0;
        peek(SR, v); check("R11 raise wins", v, 16'h0480);
    endtask

    task automatic t_disable;
        logic [15:0] v;
        @(negedge clk); err_evt = 7'h7F; @(negedge clk); err_evt = 0;
        @(negedge clk); enable = 0;
        @(negedge clk); err_evt = 7'h7F;
        @(negedge clk); err_evt = 0;
        peek(SR, v); check("R12 cleared and blocked", v, 16'h0080);
        enable = 1;
        peek(DR, v); check("R12 data kept", v, 16'h0011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_tx();
        t_nocollide();
        t_rx();
        t_arlo();
        t_overrun();
        t_events();
        t_errors();
        t_readonly();
        t_race();
        t_disable();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule